// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block produces the time-varying fractional offset that steers a fractional-N feedback divider, so that the synthesized clock sweeps through a programmable spread-spectrum profile. It counts ticks of the phase-detector clock. The shape of the profile comes from twelve 4-bit delta samples. A running accumulator integrates them into profile levels. The block walks those levels up, back down, and then through the same two quarters with the sign inverted, which gives one triangular-like period that is symmetric about a programmable offset.

Software-visible settings arrive as plain inputs: the deltas, a sample-count field, a hold field, a 6-bit offset, an amplitude doubler and a dither enable. They are captured only when the enable rises or when a period ends. The output is a signed word in units of 1/64 of one integer divide step. A one-cycle valid strobe accompanies each new value. An error flag reports a programmed profile that would exceed the allowed fractional range.

Top module: `ssc_profile_gen`

## Requirements
- R1: With U used samples and level L_k defined as the sum of deltas 0..k-1 (L_0 = 0), the profile steps s = 0..4U-1 produce the following, where q = s/U and j = s mod U. For q = 0 and q = 2 the level is L_j. For q = 1 and q = 3 the level is L_(U-j). The level is negated in quarters 2 and 3. Delta k sits in bits [4k+3:4k] of `deltaSamples`.
- R2: Each profile step lasts `holdSel` + 2 clock cycles. `fracValid` is high for exactly one cycle, on the cycle after each step starts, and `fracWord` changes only at those points.
- R3: U equals 2 × `sampleCount`. One period is 4U steps. Settings that change during a period have no effect until the period ends. At the end of a period they are resampled, and the next period starts at step 0 with no extra gap.
- R4: `fracWord` is the signed 10-bit two's-complement value offset + (±scaled level), where the offset is the captured `offsetSel`.
- R5: When the captured `doubleAmp` is 1, the integrated level is multiplied by 2 before the offset is added.
- R6: When the captured `ditherEn` is 1, bit 0 of each new `fracWord` is replaced by bit 0 of a 16-bit LFSR. The LFSR is seeded 16'hACE1 at reset. After every update, whether or not dither is on, it shifts left and takes in bit15^bit13^bit12^bit10 at bit 0.
- R7: While `enable` is low, `fracValid` is 0, and one cycle later `fracWord` equals the current `offsetSel`. When `enable` is sampled high after being low, the settings are captured, and step 0 is output one cycle later.
- R8: At each capture, `cfgError` is set to 1 if the sum of the U used deltas plus the offset exceeds 63, and to 0 otherwise. Deltas beyond the used ones are ignored.
- R9: A `sampleCount` of 0 is treated as 1, and a value of 7 is treated as 6. Either of these values also sets `cfgError` at capture.
- R10: During reset, `fracWord` is 0, `fracValid` is 0 and `cfgError` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the modulation when high |
| deltaSamples | input | 48 | Twelve 4-bit delta samples, sample k in bits [4k+3:4k] |
| sampleCount | input | 3 | Used samples = 2 × this field (valid 1 to 6) |
| holdSel | input | 4 | Step hold time = this + 2 cycles |
| offsetSel | input | 6 | Fractional offset added to the profile |
| doubleAmp | input | 1 | Doubles the profile amplitude |
| ditherEn | input | 1 | Replaces the output LSB with a pseudo-random bit |
| fracWord | output | 10 | Signed fraction word, 1/64 divide-step units |
| fracValid | output | 1 | One-cycle strobe marking a new fraction word |
| cfgError | output | 1 | Captured settings break the range limit or count rule |

## Verification
Suppose the enable is sampled high at clock edge E. Capture happens at E, and the first word and valid strobe appear after edge E+1. Every later word appears exactly holdSel+2 edges after the previous one, including across a period boundary, where the old hold length still governs the last gap. `cfgError` is due after the capture edge, and the disabled-state offset is due one edge after the enable is seen low. The bench drives inputs on falling edges and samples on the falling edge after each due edge. It also checks that valid is low on the falling edge immediately after every update, which proves the strobe lasts a single cycle.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int NUM_SAMPLES = 12;
  localparam int SAMPLE_W    = 4;
  localparam int CNT_W       = 3;
  localparam int HOLD_W      = 4;
  localparam int OFFSET_W    = 6;
  localparam int LFSR_W      = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  localparam int MAX_CNT    = NUM_SAMPLES / 2;
  localparam int MAX_SUM    = NUM_SAMPLES * ((1 << SAMPLE_W) - 1);
  localparam int ACC_W      = $clog2(MAX_SUM + 1);
  localparam int OUT_W      = $clog2(2 * MAX_SUM + (1 << OFFSET_W)) + 1;
  localparam int IDX_W      = $clog2(NUM_SAMPLES);
  localparam int USED_W     = $clog2(NUM_SAMPLES + 1);
  localparam int HOLD_CNT_W = $clog2((1 << HOLD_W) + 2);
  localparam int RANGE_LIM  = (1 << OFFSET_W) - 1;

  typedef struct packed {
    logic             load;
    logic             update;
    logic             accAdd;
    logic             accSub;
    logic             negate;
    logic             idle;
    logic [IDX_W-1:0] sampleSel;
  } ctrlStrobes_t;

  function automatic logic [USED_W-1:0] usedSamples(input logic [CNT_W-1:0] c);
    logic [CNT_W-1:0] eff;
    eff = c;
    if (c == '0) eff = CNT_W'(1);
    else if (int'(c) > MAX_CNT) eff = CNT_W'(MAX_CNT);
    return USED_W'({eff, 1'b0});
  endfunction

  function automatic logic countBad(input logic [CNT_W-1:0] c);
    return (c == '0) || (int'(c) > MAX_CNT);
  endfunction
endpackage

// File: rtl/ssc_ctrl.sv
module ssc_ctrl
  import ssc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [CNT_W-1:0]  sampleCount,
  input  logic [HOLD_W-1:0] holdSel,
  output ctrlStrobes_t      strobes
);
  logic                  running;
  logic [1:0]            quarter;
  logic [IDX_W-1:0]      stepIdx;
  logic [HOLD_CNT_W-1:0] holdCnt;
  logic [HOLD_CNT_W-1:0] holdLen;
  logic [USED_W-1:0]     usedCnt;

  logic lastHold;
  logic lastStep;
  logic periodEnd;
  logic active;

  assign active    = running && enable;
  assign lastHold  = (holdCnt == holdLen - HOLD_CNT_W'(1));
  assign lastStep  = (stepIdx == IDX_W'(usedCnt - USED_W'(1)));
  assign periodEnd = active && lastHold && lastStep && (quarter == 2'd3);

  always_comb begin
    strobes        = '0;
    strobes.idle   = !enable;
    strobes.load   = enable && (!running || periodEnd);
    strobes.update = active && (holdCnt == '0);
    strobes.accAdd = active && lastHold && !quarter[0];
    strobes.accSub = active && lastHold && quarter[0];
    strobes.negate = quarter[1];
    if (quarter[0])
      strobes.sampleSel = IDX_W'(usedCnt) - IDX_W'(1) - stepIdx;
    else
      strobes.sampleSel = stepIdx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      quarter <= '0;
      stepIdx <= '0;
      holdCnt <= '0;
      holdLen <= HOLD_CNT_W'(2);
      usedCnt <= USED_W'(2);
    end else if (!enable) begin
      running <= 1'b0;
    end else if (strobes.load) begin
      running <= 1'b1;
      quarter <= '0;
      stepIdx <= '0;
      holdCnt <= '0;
      holdLen <= HOLD_CNT_W'(holdSel) + HOLD_CNT_W'(2);
      usedCnt <= usedSamples(sampleCount);
    end else if (running) begin
      if (lastHold) begin
        holdCnt <= '0;
        if (lastStep) begin
          stepIdx <= '0;
          quarter <= quarter + 2'd1;
        end else begin
          stepIdx <= stepIdx + IDX_W'(1);
        end
      end else begin
        holdCnt <= holdCnt + HOLD_CNT_W'(1);
      end
    end
  end

  // R3: the step index never leaves the used window
  p_idx_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (USED_W'(stepIdx) < usedCnt));

  // R2: the hold counter stays inside the programmed hold length
  p_hold_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (holdCnt < holdLen));

  // R2: two updates are never adjacent
  p_update_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.update |=> !strobes.update);
endmodule

// File: rtl/ssc_datapath.sv
module ssc_datapath
  import ssc_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  ctrlStrobes_t                    strobes,
  input  logic [NUM_SAMPLES*SAMPLE_W-1:0] deltaIn,
  input  logic [CNT_W-1:0]                sampleCount,
  input  logic [OFFSET_W-1:0]             offsetIn,
  input  logic                            doubleIn,
  input  logic                            ditherIn,
  output logic signed [OUT_W-1:0]         fracWord,
  output logic                            fracValid,
  output logic                            cfgError
);
  logic [SAMPLE_W-1:0] deltaNow [NUM_SAMPLES];
  logic [SAMPLE_W-1:0] deltaReg [NUM_SAMPLES];
  logic [OFFSET_W-1:0] offsetReg;
  logic                doubleReg;
  logic                ditherReg;
  logic [ACC_W-1:0]    acc;
  logic [LFSR_W-1:0]   lfsr;
  logic [LFSR_W-1:0]   lfsrNext;

  logic [ACC_W:0]          usedSum;
  logic [USED_W-1:0]       usedNow;
  logic                    errNow;
  logic signed [OUT_W-1:0] magS;
  logic signed [OUT_W-1:0] offS;
  logic signed [OUT_W-1:0] nextWord;

  for (genvar k = 0; k < NUM_SAMPLES; k++) begin : g_unpack
    assign deltaNow[k] = deltaIn[k*SAMPLE_W +: SAMPLE_W];
  end

  always_comb begin
    usedNow = usedSamples(sampleCount);
    usedSum = '0;
    for (int k = 0; k < NUM_SAMPLES; k++) begin
      if (k < int'(usedNow)) usedSum = usedSum + (ACC_W+1)'(deltaNow[k]);
    end
    errNow = countBad(sampleCount) ||
             ((usedSum + (ACC_W+1)'(offsetIn)) > (ACC_W+1)'(RANGE_LIM));
  end

  assign lfsrNext = {lfsr[LFSR_W-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  always_comb begin
    magS = OUT_W'(acc);
    if (doubleReg) magS = magS <<< 1;
    offS     = OUT_W'(offsetReg);
    nextWord = strobes.negate ? (offS - magS) : (offS + magS);
    if (ditherReg) nextWord[0] = lfsr[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_SAMPLES; k++) deltaReg[k] <= '0;
      offsetReg <= '0;
      doubleReg <= 1'b0;
      ditherReg <= 1'b0;
      acc       <= '0;
      cfgError  <= 1'b0;
    end else if (strobes.load) begin
      for (int k = 0; k < NUM_SAMPLES; k++) deltaReg[k] <= deltaNow[k];
      offsetReg <= offsetIn;
      doubleReg <= doubleIn;
      ditherReg <= ditherIn;
      acc       <= '0;
      cfgError  <= errNow;
    end else if (strobes.accAdd) begin
      acc <= acc + ACC_W'(deltaReg[strobes.sampleSel]);
    end else if (strobes.accSub) begin
      acc <= acc - ACC_W'(deltaReg[strobes.sampleSel]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fracWord  <= '0;
      fracValid <= 1'b0;
      lfsr      <= LFSR_SEED;
    end else if (strobes.idle) begin
      fracWord  <= OUT_W'(offsetIn);
      fracValid <= 1'b0;
    end else if (strobes.update) begin
      fracWord  <= nextWord;
      fracValid <= 1'b1;
      lfsr      <= lfsrNext;
    end else begin
      fracValid <= 1'b0;
    end
  end

  // R1: the integrator never underflows or exceeds the largest sum
  p_acc_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(acc) <= MAX_SUM);

  // R6: the dither source never locks up at zero
  p_lfsr_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);

  // R2: every update strobe is followed by a valid word
  p_valid_follows_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.update |=> fracValid);
endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen
  import ssc_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            enable,
  input  logic [NUM_SAMPLES*SAMPLE_W-1:0] deltaSamples,
  input  logic [CNT_W-1:0]                sampleCount,
  input  logic [HOLD_W-1:0]               holdSel,
  input  logic [OFFSET_W-1:0]             offsetSel,
  input  logic                            doubleAmp,
  input  logic                            ditherEn,
  output logic signed [OUT_W-1:0]         fracWord,
  output logic                            fracValid,
  output logic                            cfgError
);
  ctrlStrobes_t strobes;

  ssc_ctrl i_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .sampleCount (sampleCount),
    .holdSel     (holdSel),
    .strobes     (strobes)
  );

  ssc_datapath i_datapath (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .deltaIn     (deltaSamples),
    .sampleCount (sampleCount),
    .offsetIn    (offsetSel),
    .doubleIn    (doubleAmp),
    .ditherIn    (ditherEn),
    .fracWord    (fracWord),
    .fracValid   (fracValid),
    .cfgError    (cfgError)
  );

  // R7: a low enable parks the output at the offset with no strobe
  p_idle_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!fracValid && ($unsigned(fracWord) == OUT_W'($past(offsetSel)))));
endmodule

// File: tb/test_ssc_profile_gen.sv
`timescale 1ns/1ps
module test_ssc_profile_gen;
  typedef struct packed {
    logic [47:0] d;
    logic [2:0]  cnt;
    logic [3:0]  hold;
    logic [5:0]  off;
    logic        dbl;
    logic        dith;
    logic        expErr;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{48'h000000000053, 3'd1, 4'd0,  6'd0,  1'b0, 1'b0, 1'b0},
    '{48'h000000654321, 3'd3, 4'd3,  6'd20, 1'b1, 1'b0, 1'b0},
    '{48'h999999998642, 3'd2, 4'd1,  6'd10, 1'b0, 1'b1, 1'b0},
    '{48'hFFFFFFFFFFFF, 3'd6, 4'd0,  6'd63, 1'b1, 1'b0, 1'b1},
    '{48'h000000000019, 3'd0, 4'd15, 6'd7,  1'b0, 1'b0, 1'b1},
    '{48'h3C1A2B4D5E6F, 3'd7, 4'd2,  6'd0,  1'b0, 1'b1, 1'b1},
    '{48'h0000000000FF, 3'd1, 4'd0,  6'd33, 1'b0, 1'b0, 1'b0},
    '{48'h0000000000FF, 3'd1, 4'd0,  6'd34, 1'b0, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [47:0] deltaSamples = '0;
  logic [2:0]  sampleCount = '0;
  logic [3:0]  holdSel = '0;
  logic [5:0]  offsetSel = 6'd5;
  logic        doubleAmp = 1'b0;
  logic        ditherEn = 1'b0;
  logic signed [9:0] fracWord;
  logic        fracValid;
  logic        cfgError;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [15:0] lfsrM = 16'hACE1;

  always #5 clk = ~clk;

  ssc_profile_gen i_ssc_profile_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .deltaSamples(deltaSamples),
    .sampleCount(sampleCount), .holdSel(holdSel), .offsetSel(offsetSel),
    .doubleAmp(doubleAmp), .ditherEn(ditherEn), .fracWord(fracWord),
    .fracValid(fracValid), .cfgError(cfgError)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int usedOf(input logic [2:0] c);
    int e;
    e = int'(c);
    if (e == 0) e = 1;
    if (e > 6) e = 6;
    return 2 * e;
  endfunction

  function automatic int holdOf(input vec_t v);
    return int'(v.hold) + 2;
  endfunction

  function automatic int levelAt(input vec_t v, input int s);
    int u, q, j, idx, lvl;
    u = usedOf(v.cnt);
    q = s / u;
    j = s % u;
    idx = (q % 2 == 0) ? j : u - j;
    lvl = 0;
    for (int k = 0; k < idx; k++) lvl += int'(v.d[4*k +: 4]);
    if (v.dbl) lvl = 2 * lvl;
    return int'(v.off) + ((q >= 2) ? -lvl : lvl);
  endfunction

  task automatic applyCfg(input vec_t v);
    deltaSamples = v.d;
    sampleCount  = v.cnt;
    holdSel      = v.hold;
    offsetSel    = v.off;
    doubleAmp    = v.dbl;
    ditherEn     = v.dith;
  endtask

  // Positioned on the falling edge after an update (or preWait cycles before one).
  task automatic runSteps(input vec_t v, input vec_t nextV, input bit change,
                          input int nSteps, input int preWait);
    int e;
    for (int s = 0; s < nSteps; s++) begin
      if (s > 0 || preWait > 0) begin
        @(posedge clk);
        @(negedge clk);
        chk(fracValid == 1'b0, "R2 valid single cycle", int'(fracValid), 0);
        repeat (((s == 0) ? preWait : holdOf(v)) - 1) @(posedge clk);
        @(negedge clk);
      end
      e = levelAt(v, s);
      if (v.dith) e = (e & ~1) | int'(lfsrM[0]);
      lfsrM = {lfsrM[14:0], lfsrM[15] ^ lfsrM[13] ^ lfsrM[12] ^ lfsrM[10]};
      chk(fracValid == 1'b1, "R2 valid at step", int'(fracValid), 1);
      chk(int'(fracWord) == e, "R1 R4 R5 R6 word", int'(fracWord), e);
      if (change && s == 1) applyCfg(nextV);
    end
  endtask

  task automatic startRun(input vec_t v);
    applyCfg(v);
    enable = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic stopRun(input int expOff);
    enable = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(fracValid == 1'b0, "R7 valid low when disabled", int'(fracValid), 0);
    chk(int'(fracWord) == expOff, "R7 offset when disabled", int'(fracWord), expOff);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(int'(fracWord) == 0, "R10 word in reset", int'(fracWord), 0);
    chk(fracValid == 1'b0, "R10 valid in reset", int'(fracValid), 0);
    chk(cfgError == 1'b0, "R10 error in reset", int'(cfgError), 0);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(int'(fracWord) == 5, "R7 offset after reset", int'(fracWord), 5);
    chk(fracValid == 1'b0, "R7 valid after reset", int'(fracValid), 0);

    // Table walk: each vector runs one full period (R1 R3 R4 R5 R6 R8 R9)
    for (int i = 0; i < NV; i++) begin
      startRun(VECS[i]);
      chk(cfgError == VECS[i].expErr, "R8 R9 range error flag",
          int'(cfgError), int'(VECS[i].expErr));
      runSteps(VECS[i], VECS[i], 1'b0, 4 * usedOf(VECS[i].cnt), 0);
      stopRun(int'(VECS[i].off));
    end

    // R3: settings changed mid-period wait for the boundary, then two periods repeat
    startRun(VECS[1]);
    runSteps(VECS[1], VECS[0], 1'b1, 4 * usedOf(VECS[1].cnt), 0);
    runSteps(VECS[0], VECS[0], 1'b0, 4 * usedOf(VECS[0].cnt), holdOf(VECS[1]));
    chk(cfgError == 1'b0, "R3 error resampled at boundary", int'(cfgError), 0);
    runSteps(VECS[0], VECS[0], 1'b0, 4 * usedOf(VECS[0].cnt), holdOf(VECS[0]));
    stopRun(int'(VECS[0].off));

    // R3 R8: boundary resample also refreshes the error flag
    startRun(VECS[6]);
    runSteps(VECS[6], VECS[7], 1'b1, 4 * usedOf(VECS[6].cnt), 0);
    runSteps(VECS[7], VECS[7], 1'b0, 1, holdOf(VECS[6]));
    chk(cfgError == 1'b1, "R8 error set at boundary", int'(cfgError), 1);
    stopRun(int'(VECS[7].off));

    // R7: disable mid-period, offset follows input, re-enable restarts at step 0
    startRun(VECS[2]);
    runSteps(VECS[2], VECS[2], 1'b0, 3, 0);
    stopRun(int'(VECS[2].off));
    offsetSel = 6'd44;
    @(posedge clk);
    @(negedge clk);
    chk(int'(fracWord) == 44, "R7 offset tracks input while idle", int'(fracWord), 44);
    startRun(VECS[2]);
    runSteps(VECS[2], VECS[2], 1'b0, 4 * usedOf(VECS[2].cnt), 0);
    stopRun(int'(VECS[2].off));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule